// File: doc/BRIEF.md
# SRAM Bus Timing Monitor

This block is a passive observer for the bus of an asynchronous static RAM. It samples the memory's control strobes, address, write data and a host flag that says the host is driving the data lines, all on a fast reference clock. Every access is timed in clock ticks. Each timing rule has its own sticky violation flag, raised when a minimum duration is not met or when the bus sees contention. The block never drives the bus.

A write is taken to be active only while all three strobes agree: the active-low select is low, the active-high select is high and the active-low write enable is low. The write starts when that condition first becomes true and ends when it first becomes false, whichever strobe caused the change. The pulse width, the select-to-end time, the address-to-end time and the data setup time are all measured against this window.

Speed grade and tick period are parameters. Nanosecond limits are rounded up to whole ticks, and a measured count passes when it is at least that tick limit. A free-running event counter counts finished writes and finished reads, so a test can line up flags with traffic.

Top module: `sram_timing_monitor`

## Requirements
- R1: The write window is open on a sample where `sel_lo_n_i`=0, `sel_hi_i`=1 and `wr_en_n_i`=0. It starts on the first such sample and ends on the first sample after that where the condition is false. A low write enable while the device is deselected is not a write.
- R2: At write end, if the window lasted fewer than `ceil(WP_ns*1000/CLK_PS)` samples (WP_ns = 40/50/60 for GRADE 0/1/2), flag bit 0 is set.
- R3: At write end, if the device had been continuously selected for fewer than `ceil(CW_ns*1000/CLK_PS)` samples (CW_ns = 45/60/70), flag bit 1 is set.
- R4: At write end, if the address had been unchanged for fewer than the same 45/60/70 ns limit in ticks, flag bit 2 is set.
- R5: At write end, if the write data had been unchanged for fewer than `ceil(DW_ns*1000/CLK_PS)` samples (DW_ns = 20/25/35), flag bit 3 is set.
- R6: Flag bit 4 is set on an address change in either of two cases: the window was open on the previous sample, or the device was selected on the previous sample and the old address had been held for fewer than `ceil(RC_ns*1000/CLK_PS)` samples (RC_ns = 55/70/85).
- R7: Flag bit 5 is set when `host_drv_i`=1 on a sample where the device is in its read state (selected, `rd_en_n_i`=0, `wr_en_n_i`=1).
- R8: Flags are sticky. They change only when `clr_i` is high, which zeroes all flags except those raised by the same sample.
- R9: `evt_cnt_o` adds one at each write end. It also adds one at each read completion, which is a sample with `rd_en_n_i`=1 that follows a sample in the read state. The counter wraps.
- R10: With the defaults (GRADE 0, CLK_PS 5000) the tick limits are: pulse 8, select and address 9, data 4, cycle 11. A duration equal to its limit passes.
- R11: Outputs are registered and show a sample one clock later. After reset, `viol_o` and `evt_cnt_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference sampling clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| clr_i | input | 1 | Synchronous clear of the violation flags |
| addr_i | input | AW | Sampled address lines |
| data_i | input | DW | Sampled write data lines |
| sel_lo_n_i | input | 1 | Active-low chip select strobe |
| sel_hi_i | input | 1 | Active-high chip select strobe |
| rd_en_n_i | input | 1 | Active-low output enable strobe |
| wr_en_n_i | input | 1 | Active-low write enable strobe |
| host_drv_i | input | 1 | High while the host drives the data lines |
| viol_o | output | 6 | Sticky flags: 0 pulse, 1 select-to-end, 2 address-to-end, 3 data setup, 4 address hold, 5 contention |
| evt_cnt_o | output | EVW | Count of completed writes and reads |

## Verification
The assertions check four things on every cycle: flags never drop without a clear, a clear with no new fault empties the flags, contention in the read state raises its flag, and each write end steps the counter by exactly one. A short write window must also raise the pulse flag. Only the bench scenarios can show the exact tick boundaries, where a duration equal to its limit passes and one tick less fails. The same goes for the window being found from whichever strobe moved last, and for address changes made while deselected raising nothing. A behavioural timestamp model in the bench follows every sample to confirm these outcomes.

// File: rtl/sram_mon_pkg.sv
package sram_mon_pkg;

    localparam int NRULE    = 6;
    localparam int V_PULSE  = 0;
    localparam int V_SELW   = 1;
    localparam int V_ADDRW  = 2;
    localparam int V_DSETUP = 3;
    localparam int V_AHOLD  = 4;
    localparam int V_CONT   = 5;

    localparam int K_PULSE = 0;
    localparam int K_SELW  = 1;
    localparam int K_DSET  = 2;
    localparam int K_CYC   = 3;

    // Minimum nanoseconds per rule kind and speed grade (0 fastest).
    function automatic int grade_ns(input int grade, input int kind);
        int r;
        case (kind)
            K_PULSE: r = (grade == 0) ? 40 : (grade == 1) ? 50 : 60;
            K_SELW:  r = (grade == 0) ? 45 : (grade == 1) ? 60 : 70;
            K_DSET:  r = (grade == 0) ? 20 : (grade == 1) ? 25 : 35;
            default: r = (grade == 0) ? 55 : (grade == 1) ? 70 : 85;
        endcase
        return r;
    endfunction

    // Round a nanosecond limit up to whole ticks of CLK_PS picoseconds.
    function automatic int ns_to_ticks(input int ns, input int ps);
        return (ns * 1000 + ps - 1) / ps;
    endfunction

endpackage

// File: rtl/sram_mon_decode.sv
module sram_mon_decode (
    input  logic sel_lo_n_i,
    input  logic sel_hi_i,
    input  logic rd_en_n_i,
    input  logic wr_en_n_i,
    output logic sel_o,
    output logic wr_act_o,
    output logic rd_drv_o
);
    always_comb begin
        sel_o    = !sel_lo_n_i && sel_hi_i;
        wr_act_o = sel_o && !wr_en_n_i;
        rd_drv_o = sel_o && !rd_en_n_i && wr_en_n_i;
    end
endmodule

// File: rtl/sram_mon_age.sv
module sram_mon_age #(
    parameter int W = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         restart_i,
    input  logic         run_i,
    output logic [W-1:0] age_o
);
    localparam logic [W-1:0] AGE_MAX = {W{1'b1}};

    logic [W-1:0] age_d, age_q;

    always_comb begin
        if (restart_i)               age_d = W'(1);
        else if (!run_i)             age_d = '0;
        else if (age_q == AGE_MAX)   age_d = age_q;
        else                         age_d = age_q + W'(1);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) age_q <= '0;
        else         age_q <= age_d;
    end

    assign age_o = age_q;
endmodule

// File: rtl/sram_timing_monitor.sv
module sram_timing_monitor
    import sram_mon_pkg::*;
#(
    parameter int AW     = 17,
    parameter int DW     = 8,
    parameter int EVW    = 16,
    parameter int GRADE  = 0,
    parameter int CLK_PS = 5000
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [DW-1:0]    data_i,
    input  logic             sel_lo_n_i,
    input  logic             sel_hi_i,
    input  logic             rd_en_n_i,
    input  logic             wr_en_n_i,
    input  logic             host_drv_i,
    output logic [NRULE-1:0] viol_o,
    output logic [EVW-1:0]   evt_cnt_o
);
    localparam int L_PULSE = ns_to_ticks(grade_ns(GRADE, K_PULSE), CLK_PS);
    localparam int L_SELW  = ns_to_ticks(grade_ns(GRADE, K_SELW),  CLK_PS);
    localparam int L_DSET  = ns_to_ticks(grade_ns(GRADE, K_DSET),  CLK_PS);
    localparam int L_CYC   = ns_to_ticks(grade_ns(GRADE, K_CYC),   CLK_PS);
    localparam int CW      = $clog2(L_CYC + 2);
    localparam int NAGE    = 4;
    localparam int A_PULSE = 0;
    localparam int A_SEL   = 1;
    localparam int A_ADDR  = 2;
    localparam int A_DATA  = 3;

    localparam logic [CW-1:0] LIM_PULSE = CW'(L_PULSE);
    localparam logic [CW-1:0] LIM_SELW  = CW'(L_SELW);
    localparam logic [CW-1:0] LIM_DSET  = CW'(L_DSET);
    localparam logic [CW-1:0] LIM_CYC   = CW'(L_CYC);

    typedef struct packed {
        logic [AW-1:0]    addr;
        logic [DW-1:0]    data;
        logic             sel;
        logic             wr;
        logic             rd;
        logic [NRULE-1:0] viol;
        logic [EVW-1:0]   cnt;
    } mon_st_t;

    mon_st_t st_d, st_q;

    logic sel_now, wr_now, rd_now;
    logic addr_chg, data_chg, wr_end, rd_done;
    logic [NRULE-1:0] new_viol;
    logic [NAGE-1:0]  age_restart, age_run;
    logic [CW-1:0]    age [NAGE];

    sram_mon_decode u_decode (
        .sel_lo_n_i (sel_lo_n_i),
        .sel_hi_i   (sel_hi_i),
        .rd_en_n_i  (rd_en_n_i),
        .wr_en_n_i  (wr_en_n_i),
        .sel_o      (sel_now),
        .wr_act_o   (wr_now),
        .rd_drv_o   (rd_now)
    );

    always_comb begin
        addr_chg = (addr_i != st_q.addr);
        data_chg = (data_i != st_q.data);
        wr_end   = st_q.wr && !wr_now;
        rd_done  = st_q.rd && rd_en_n_i;

        age_restart[A_PULSE] = wr_now && !st_q.wr;
        age_run[A_PULSE]     = wr_now;
        age_restart[A_SEL]   = sel_now && !st_q.sel;
        age_run[A_SEL]       = sel_now;
        age_restart[A_ADDR]  = addr_chg;
        age_run[A_ADDR]      = 1'b1;
        age_restart[A_DATA]  = data_chg;
        age_run[A_DATA]      = 1'b1;
    end

    for (genvar g = 0; g < NAGE; g++) begin : g_age
        sram_mon_age #(.W(CW)) u_age (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .restart_i (age_restart[g]),
            .run_i     (age_run[g]),
            .age_o     (age[g])
        );
    end

    always_comb begin
        new_viol = '0;
        if (wr_end) begin
            new_viol[V_PULSE]  = age[A_PULSE] < LIM_PULSE;
            new_viol[V_SELW]   = age[A_SEL]   < LIM_SELW;
            new_viol[V_ADDRW]  = age[A_ADDR]  < LIM_SELW;
            new_viol[V_DSETUP] = age[A_DATA]  < LIM_DSET;
        end
        new_viol[V_AHOLD] = addr_chg &&
                            (st_q.wr || (st_q.sel && age[A_ADDR] < LIM_CYC));
        new_viol[V_CONT]  = host_drv_i && rd_now;

        st_d      = st_q;
        st_d.addr = addr_i;
        st_d.data = data_i;
        st_d.sel  = sel_now;
        st_d.wr   = wr_now;
        st_d.rd   = rd_now;
        st_d.viol = (clr_i ? '0 : st_q.viol) | new_viol;
        if (wr_end || rd_done) st_d.cnt = st_q.cnt + EVW'(1);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign viol_o    = st_q.viol;
    assign evt_cnt_o = st_q.cnt;

    // R8: flags never drop unless cleared
    assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_i |=> ((viol_o & $past(viol_o)) == $past(viol_o)));

    // R8: a clear with nothing new empties the flags
    assert_clear_empty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && new_viol == '0) |=> (viol_o == '0));

    // R7: host driving while the device reads raises contention
    assert_contention_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (host_drv_i && rd_now) |=> viol_o[V_CONT]);

    // R9: each write end steps the event counter by one
    assert_write_count_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.wr && !wr_now) |=> ((evt_cnt_o - $past(evt_cnt_o)) == EVW'(1)));

    // R2: a short write window is reported
    assert_short_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.wr && !wr_now && age[A_PULSE] < LIM_PULSE) |=> viol_o[V_PULSE]);

endmodule

// File: tb/sram_timing_monitor_tb.sv
module sram_timing_monitor_tb;
    localparam int AW = 17;
    localparam int DW = 8;
    localparam int EVW = 16;
    localparam int CLK_PS = 5000;
    localparam int IDLE = 12;

    function automatic int ticks(input int ns);
        return (ns * 1000 + CLK_PS - 1) / CLK_PS;
    endfunction

    localparam int LWP = 8, LSEL = 9, LDW = 4, LRC = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic s_lo_n = 1'b1, s_hi = 1'b0, rd_n = 1'b1, wr_n = 1'b1, host = 1'b0;
    logic [5:0] viol;
    logic [EVW-1:0] cnt;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    sram_timing_monitor u_dut (
        .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .addr_i(addr), .data_i(din),
        .sel_lo_n_i(s_lo_n), .sel_hi_i(s_hi), .rd_en_n_i(rd_n), .wr_en_n_i(wr_n),
        .host_drv_i(host), .viol_o(viol), .evt_cnt_o(cnt)
    );

    // ---------------- behavioural timestamp model ----------------
    int t, t_a, t_d, t_wr, t_sel;
    logic [AW-1:0] a_p;
    logic [DW-1:0] d_p;
    bit sel_p, wa_p, rd_p;
    logic [5:0] m_viol;
    int m_cnt;

    always @(posedge clk) begin
        bit sel, wa, rd;
        logic [5:0] nv;
        if (!rst_n) begin
            t = 0; t_a = 0; t_d = 0; t_wr = 0; t_sel = 0;
            a_p = '0; d_p = '0; sel_p = 0; wa_p = 0; rd_p = 0;
            m_viol = '0; m_cnt = 0;
        end else begin
            sel = !s_lo_n && s_hi;
            wa  = sel && !wr_n;
            rd  = sel && !rd_n && wr_n;
            nv  = '0;
            if (wa_p && !wa) begin
                if (t - t_wr  < LWP)  nv[0] = 1'b1;
                if (t - t_sel < LSEL) nv[1] = 1'b1;
                if (t - t_a   < LSEL) nv[2] = 1'b1;
                if (t - t_d   < LDW)  nv[3] = 1'b1;
                m_cnt++;
            end
            if (addr != a_p && (wa_p || (sel_p && (t - t_a) < LRC))) nv[4] = 1'b1;
            if (host && rd) nv[5] = 1'b1;
            if (rd_p && rd_n) m_cnt++;
            m_viol = (clr ? 6'b0 : m_viol) | nv;
            if (addr != a_p) t_a = t;
            if (din != d_p) t_d = t;
            if (wa && !wa_p) t_wr = t;
            if (sel && !sel_p) t_sel = t;
            a_p = addr; d_p = din; sel_p = sel; wa_p = wa; rd_p = rd;
            t++;
        end
    end

    string tags [6] = '{"R2", "R3", "R4", "R5", "R6", "R7"};

    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int b = 0; b < 6; b++) begin
                checks++;
                if (viol[b] !== m_viol[b]) begin
                    errors++;
                    $display("FAIL %s model flag bit %0d actual=%0b expected=%0b at t=%0d",
                             tags[b], b, viol[b], m_viol[b], t);
                end
            end
            checks++;
            if (cnt !== EVW'(m_cnt)) begin
                errors++;
                $display("FAIL R9 model count actual=%0d expected=%0d", cnt, m_cnt);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic deselect();
        s_lo_n = 1'b1; s_hi = 1'b0; wr_n = 1'b1; rd_n = 1'b1; host = 1'b0;
    endtask

    task automatic do_clear();
        clr = 1'b1; step(1); clr = 1'b0; step(1);
        chk("R8 clear", int'(viol), 0);
    endtask

    task automatic write_cyc(input logic [AW-1:0] a, input logic [DW-1:0] d,
                             input int sel_lead, input int pulse, input int dlead,
                             input bit late, input int mid);
        deselect();
        din = ~d;
        if (!late) addr = a;
        step(IDLE);
        s_lo_n = 1'b0; s_hi = 1'b1;
        step(sel_lead);
        wr_n = 1'b0;
        for (int k = 0; k < pulse; k++) begin
            if (k == 0 && late) addr = a;
            if (mid > 0 && k == mid) addr = a + 1;
            if (k == pulse - dlead) din = d;
            step(1);
        end
        wr_n = 1'b1;
        step(1);
        deselect();
        step(3);
    endtask

    task automatic read_cyc(input logic [AW-1:0] a, input int h1, input int h2,
                            input bit contend);
        deselect();
        addr = a;
        step(IDLE);
        s_lo_n = 1'b0; s_hi = 1'b1; rd_n = 1'b0;
        host = contend;
        step(h1);
        host = 1'b0;
        addr = a + 1;
        step(h2);
        addr = a + 2;
        step(2);
        rd_n = 1'b1;
        step(1);
        deselect();
        step(3);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        chk("R11 reset flags", int'(viol), 0);
        chk("R11 reset count", int'(cnt), 0);
        chk("R10 limit pulse", ticks(40), LWP);
        chk("R10 limit select", ticks(45), LSEL);
        chk("R10 limit data", ticks(20), LDW);
        chk("R10 limit cycle", ticks(55), LRC);

        // R1: write enable low with the active-high select low is no write
        s_lo_n = 1'b0; s_hi = 1'b0; wr_n = 1'b0;
        step(12);
        deselect(); step(3);
        chk("R1 deselected strobe not a write", int'(cnt), 0);

        write_cyc(17'h00010, 8'h5A, 3, 10, 6, 0, 0);
        chk("R1 clean write flags", int'(viol), 0);
        chk("R1 R9 write counted", int'(cnt), 1);

        write_cyc(17'h00020, 8'h3C, 2, LWP, LDW, 0, 0);
        chk("R10 boundary pulse and data pass", int'(viol), 0);
        chk("R9 count", int'(cnt), 2);

        write_cyc(17'h00030, 8'h11, 2, LWP - 1, 5, 0, 0);
        chk("R2 short pulse", int'(viol), 6'b000001);
        step(6);
        chk("R8 sticky after idle", int'(viol), 6'b000001);
        do_clear();

        write_cyc(17'h00040, 8'h22, 0, 8, 4, 0, 0);
        chk("R3 select to end short", int'(viol), 6'b000010);
        do_clear();

        write_cyc(17'h00050, 8'h33, 2, 8, 4, 1, 0);
        chk("R4 address to end short", int'(viol), 6'b000100);
        do_clear();

        write_cyc(17'h00060, 8'h44, 2, 9, 3, 0, 0);
        chk("R5 data setup short", int'(viol), 6'b001000);
        do_clear();

        write_cyc(17'h00070, 8'h55, 2, 10, 4, 0, 5);
        chk("R6 address moved in write", int'(viol), 6'b010100);
        chk("R9 count after writes", int'(cnt), 7);
        do_clear();

        read_cyc(17'h00100, 4, 3, 0);
        chk("R6 read cycle too short", int'(viol), 6'b010000);
        chk("R9 read counted", int'(cnt), 8);
        do_clear();

        read_cyc(17'h00200, 4, LRC, 0);
        chk("R6 read cycle at limit passes", int'(viol), 0);

        read_cyc(17'h00300, 4, LRC, 1);
        chk("R7 contention", int'(viol), 6'b100000);
        chk("R9 count after reads", int'(cnt), 10);
        do_clear();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule